// File: doc/BRIEF.md
# Power-Line Alarm Status Controller

This block turns line measurements into a 24-bit alarm status word and two alarm output pins. Once per accumulation interval it receives RMS voltage and current values together with an interval-done strobe. At the high sample rate it receives a mean-square voltage value with a sample strobe. Each alarm condition compares one measurement with a programmable threshold and must persist for a programmable hold-off count before its status bit is set.

Under-voltage and over-voltage are qualified over consecutive accumulation intervals. Sag and surge are qualified over consecutive samples and share one sample hold-off count. Over-current is judged at every interval boundary with no hold-off. A per-bit policy word decides whether a set bit stays set until software clears it, or drops at each interval boundary. Software pulses can force bits set or clear them. Two independent mask words select which status bits drive each of the two registered, active-high alarm pins: a fault pin and a critical pin.

The threshold, hold-off, policy and mask values arrive as plain input words from a register bank outside this block. Software would normally program them to the following values: under-voltage and sag thresholds 95000, surge threshold 225000, and both hold-off counts 4.

Top module: `pwr_alarm_ctrl`

## Requirements
- R1: While reset is asserted (synchronous, active low), the status word and both pins are 0 after the next clock edge.
- R2: Status bit 0 (under-voltage) is set at the edge of the interval strobe on which `vrms < thr_uv` has held for `hold_ivl` consecutive interval strobes. A hold-off of 0 acts as 1.
- R3: Status bit 1 (over-voltage) follows the rule of R2 with the condition `vrms > thr_ov`.
- R4: An interval strobe whose condition is false resets that alarm's consecutive count to zero. Cycles without the alarm's strobe leave the count unchanged. The same rule applies per sample strobe for the sag and surge alarms.
- R5: Status bit 2 (sag, `vms < thr_sag`) and status bit 10 (surge, `vms > thr_surge`) are qualified per sample strobe. They use the shared count `hold_smp`, which follows the same rules as R2 and R4.
- R6: Status bit 6 (over-current) is set at any interval strobe with `irms > thr_oc`.
- R7: At each interval strobe, set bits whose `sticky_cfg` bit is 0 are cleared, and bits whose `sticky_cfg` bit is 1 are kept. Detections made at that same strobe are applied after the clearing, so they remain set.
- R8: When `clr_stb` is high, the bits in `clr_mask` are cleared, including any detection made in the same cycle.
- R9: When `frc_stb` is high, the bits in `frc_mask` are set. If a force and a clear hit the same bit in the same cycle, the force wins.
- R10: `pin_fault` and `pin_crit` are registered, active high. Each equals the OR of (status AND `mask_fault`) or (status AND `mask_crit`) respectively, one cycle after the status value. For example, a `mask_fault` of 0x000440 selects exactly over-current and surge.
- R11: Bits other than 0, 1, 2, 6 and 10 change only through force, clear, interval auto-clear and reset. A set bit never drops except through R7, R8 or R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ivl_done | input | 1 | Accumulation interval complete strobe |
| vrms | input | 24 | Interval RMS voltage |
| irms | input | 24 | Interval RMS current |
| smp_stb | input | 1 | High-rate sample strobe |
| vms | input | 24 | Per-sample mean-square voltage |
| thr_uv | input | 24 | Under-voltage threshold |
| thr_ov | input | 24 | Over-voltage threshold |
| thr_sag | input | 24 | Sag threshold |
| thr_surge | input | 24 | Surge threshold |
| thr_oc | input | 24 | Over-current threshold |
| hold_ivl | input | 8 | Consecutive intervals for under/over-voltage |
| hold_smp | input | 8 | Consecutive samples for sag/surge |
| sticky_cfg | input | 24 | Per-bit hold (1) or auto-clear (0) policy |
| mask_fault | input | 24 | Bits that drive the fault pin |
| mask_crit | input | 24 | Bits that drive the critical pin |
| frc_stb | input | 1 | Force pulse |
| frc_mask | input | 24 | Bits to force set |
| clr_stb | input | 1 | Clear pulse |
| clr_mask | input | 24 | Bits to clear |
| status | output | 24 | Alarm status word |
| pin_fault | output | 1 | Fault alarm pin |
| pin_crit | output | 1 | Critical alarm pin |

## Verification
The assertions accept any combination of strobes and pulses in any cycle. Force, clear, interval and sample strobes may coincide. The hold-off values may also change at any time, so no check bounds a hold-off counter against its current limit. The properties that a bit never drops therefore exclude cycles carrying a clear or an interval strobe, and the clear property excludes bits forced in the same cycle. The random stimulus keeps measurements in a band around the thresholds so that conditions toggle often. It mixes coincident force, clear and strobe pulses, and changes the policy, the masks and the hold-offs between phases. Directed phases cover exact hold-off counts, interrupted runs, a hold-off of zero, and the fault mask 0x000440.

// File: rtl/pwr_alarm_pkg.sv
// Shared constants for the power-line alarm controller.
// Bit positions are fixed because software mask words decode them.
package pwr_alarm_pkg;
    localparam int ALM_W     = 24;
    localparam int BIT_UV    = 0;
    localparam int BIT_OV    = 1;
    localparam int BIT_SAG   = 2;
    localparam int BIT_OC    = 6;
    localparam int BIT_SURGE = 10;
    localparam int NQ        = 4;   // number of hold-off qualified channels
    typedef enum int {Q_UV = 0, Q_OV = 1, Q_SAG = 2, Q_SURGE = 3} qch_e;
endpackage

// File: rtl/alarm_holdoff.sv
// Consecutive-strobe qualifier.
// It counts strobes on which the condition holds, and reports a hit on
// the strobe that completes the run. A limit of 0 behaves as 1. The
// count saturates once the run is complete, and a strobe without the
// condition restarts the run.
// Assumes strobe and condition are synchronous to clk.
module alarm_holdoff #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              cond,
    input  logic [HOLD_W-1:0] limit,
    output logic              hit
);
    logic [HOLD_W-1:0] cnt;
    logic [HOLD_W:0]   lim_eff;
    logic              reach;

    // effective limit and run-complete test
    always_comb begin
        lim_eff = (limit == '0) ? {{HOLD_W{1'b0}}, 1'b1} : {1'b0, limit};
        reach   = ({1'b0, cnt} + 1'b1) >= lim_eff;
        hit     = stb && cond && reach;
    end

    // consecutive run counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (stb) begin
            if (!cond)
                cnt <= '0;
            else if (!reach)
                cnt <= cnt + 1'b1;
        end
    end

    a_r4_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !cond) |=> (cnt == '0));
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(cnt));
endmodule

// File: rtl/alarm_status_word.sv
// Alarm status register.
// Update order within one cycle:
//   1. the interval auto-clear of the non-sticky bits
//   2. the new detections
//   3. the software clear
//   4. the software force (last, so a force beats a clear)
// Assumes all pulses are single-cycle and synchronous.
module alarm_status_word #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] det,
    input  logic [W-1:0] keep,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_mask,
    input  logic         frc_stb,
    input  logic [W-1:0] frc_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] nxt;
    logic [W-1:0] frc_eff;

    // next status in policy order
    always_comb begin
        frc_eff = frc_stb ? frc_mask : '0;
        nxt     = status;
        if (adv)     nxt = nxt & keep;
        nxt = nxt | det;
        if (clr_stb) nxt = nxt & ~clr_mask;
        nxt = nxt | frc_eff;
    end

    // status storage
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= nxt;
    end

    a_r9_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        frc_stb |=> ((status & $past(frc_mask)) == $past(frc_mask)));
    a_r8_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((status & $past(clr_mask & ~frc_eff)) == '0));
    a_r11_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr_stb) |=> ((status & $past(status)) == $past(status)));
    a_r7_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr_stb) |=> ((status & $past(status & keep)) == $past(status & keep)));
endmodule

// File: rtl/alarm_pin_drive.sv
// Registered pin drivers, one per mask word.
// Each pin is the OR of the status bits that its mask selects.
// Assumes the masks are quasi-static words from a register bank.
module alarm_pin_drive #(
    parameter int W     = 24,
    parameter int NPINS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              status,
    input  logic [NPINS-1:0][W-1:0]   masks,
    output logic [NPINS-1:0]          pins
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // masked OR, registered
        always_ff @(posedge clk) begin
            if (!rst_n) pins[p] <= 1'b0;
            else        pins[p] <= |(status & masks[p]);
        end

        a_r10_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (pins[p] == |($past(status) & $past(masks[p]))));
    end
endmodule

// File: rtl/pwr_alarm_ctrl.sv
// Power-line alarm status controller (top).
// It compares interval RMS values and the per-sample mean-square
// voltage with their thresholds, qualifies the results with hold-off
// counts, keeps the status word and drives two masked alarm pins.
// Assumes measurements are valid during their strobe cycle.
module pwr_alarm_ctrl
    import pwr_alarm_pkg::*;
#(
    parameter int MEAS_W = 24,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ivl_done,
    input  logic [MEAS_W-1:0] vrms,
    input  logic [MEAS_W-1:0] irms,
    input  logic              smp_stb,
    input  logic [MEAS_W-1:0] vms,
    input  logic [MEAS_W-1:0] thr_uv,
    input  logic [MEAS_W-1:0] thr_ov,
    input  logic [MEAS_W-1:0] thr_sag,
    input  logic [MEAS_W-1:0] thr_surge,
    input  logic [MEAS_W-1:0] thr_oc,
    input  logic [HOLD_W-1:0] hold_ivl,
    input  logic [HOLD_W-1:0] hold_smp,
    input  logic [ALM_W-1:0]  sticky_cfg,
    input  logic [ALM_W-1:0]  mask_fault,
    input  logic [ALM_W-1:0]  mask_crit,
    input  logic              frc_stb,
    input  logic [ALM_W-1:0]  frc_mask,
    input  logic              clr_stb,
    input  logic [ALM_W-1:0]  clr_mask,
    output logic [ALM_W-1:0]  status,
    output logic              pin_fault,
    output logic              pin_crit
);
    localparam int NPINS = 2;

    logic [NQ-1:0]             q_cond, q_stb, q_hit;
    logic [NQ-1:0][HOLD_W-1:0] q_lim;
    logic [ALM_W-1:0]          det;
    logic [NPINS-1:0][ALM_W-1:0] pin_masks;
    logic [NPINS-1:0]          pins;

    // per-channel condition, strobe and hold-off selection
    always_comb begin
        q_cond[Q_UV]    = vrms < thr_uv;
        q_cond[Q_OV]    = vrms > thr_ov;
        q_cond[Q_SAG]   = vms < thr_sag;
        q_cond[Q_SURGE] = vms > thr_surge;
        q_stb[Q_UV]     = ivl_done;
        q_stb[Q_OV]     = ivl_done;
        q_stb[Q_SAG]    = smp_stb;
        q_stb[Q_SURGE]  = smp_stb;
        q_lim[Q_UV]     = hold_ivl;
        q_lim[Q_OV]     = hold_ivl;
        q_lim[Q_SAG]    = hold_smp;
        q_lim[Q_SURGE]  = hold_smp;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_qual
        alarm_holdoff #(.HOLD_W(HOLD_W)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (q_stb[q]),
            .cond  (q_cond[q]),
            .limit (q_lim[q]),
            .hit   (q_hit[q])
        );
    end

    // map qualified hits and over-current onto status bit positions
    always_comb begin
        det            = '0;
        det[BIT_UV]    = q_hit[Q_UV];
        det[BIT_OV]    = q_hit[Q_OV];
        det[BIT_SAG]   = q_hit[Q_SAG];
        det[BIT_SURGE] = q_hit[Q_SURGE];
        det[BIT_OC]    = ivl_done && (irms > thr_oc);
    end

    alarm_status_word #(.W(ALM_W)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (ivl_done),
        .det      (det),
        .keep     (sticky_cfg),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .frc_stb  (frc_stb),
        .frc_mask (frc_mask),
        .status   (status)
    );

    // pack masks for the pin drivers: index 0 fault, 1 critical
    always_comb begin
        pin_masks[0] = mask_fault;
        pin_masks[1] = mask_crit;
    end

    alarm_pin_drive #(.W(ALM_W), .NPINS(NPINS)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .masks  (pin_masks),
        .pins   (pins)
    );

    assign pin_fault = pins[0];
    assign pin_crit  = pins[1];

    a_r6_oc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_done && (irms > thr_oc) && !clr_stb) |=> status[BIT_OC]);
endmodule

// File: tb/pwr_alarm_ctrl_tb.sv
// Self-checking bench: a reference model built from the requirements,
// random stimulus from a fixed seed, and directed corner phases.
module pwr_alarm_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int W     = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ivl_done = 0, smp_stb = 0, frc_stb = 0, clr_stb = 0;
    logic [23:0] vrms = 24'd120000, irms = 24'd0, vms = 24'd150000;
    logic [23:0] thr_uv = 24'd95000, thr_ov = 24'd130000, thr_sag = 24'd95000;
    logic [23:0] thr_surge = 24'd225000, thr_oc = 24'd50000;
    logic [7:0]  hold_ivl = 8'd4, hold_smp = 8'd4;
    logic [23:0] sticky_cfg = '1, mask_fault = 24'h000440, mask_crit = 24'h000003;
    logic [23:0] frc_mask = '0, clr_mask = '0;
    logic [23:0] status;
    logic        pin_fault, pin_crit;

    int n_chk = 0, n_bad = 0;
    string cur_tag = "R1";

    // reference state
    logic [23:0] m_st = '0;
    int          m_cnt [4] = '{0, 0, 0, 0};

    always #(CLK_P/2) clk = ~clk;

    pwr_alarm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ivl_done(ivl_done), .vrms(vrms), .irms(irms),
        .smp_stb(smp_stb), .vms(vms), .thr_uv(thr_uv), .thr_ov(thr_ov),
        .thr_sag(thr_sag), .thr_surge(thr_surge), .thr_oc(thr_oc),
        .hold_ivl(hold_ivl), .hold_smp(hold_smp), .sticky_cfg(sticky_cfg),
        .mask_fault(mask_fault), .mask_crit(mask_crit), .frc_stb(frc_stb),
        .frc_mask(frc_mask), .clr_stb(clr_stb), .clr_mask(clr_mask),
        .status(status), .pin_fault(pin_fault), .pin_crit(pin_crit)
    );

    task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %06h expected %06h at %0t", tag, got, exp, $time);
        end
    endtask

    // hold-off run model (R2, R4, R5): returns hit, updates count
    function automatic logic qual(input int ch, input logic stb, input logic c, input int lim);
        int l;
        l = (lim == 0) ? 1 : lim;
        if (!stb) return 1'b0;
        if (!c) begin m_cnt[ch] = 0; return 1'b0; end
        if (m_cnt[ch] + 1 >= l) return 1'b1;
        m_cnt[ch]++;
        return 1'b0;
    endfunction

    // one clock: predict, apply edge, compare away from the edge
    task automatic cyc();
        logic [23:0] d, nxt, old;
        logic ef, ec;
        old = m_st;
        d = '0;
        d[0]  = qual(0, ivl_done, vrms < thr_uv, int'(hold_ivl));
        d[1]  = qual(1, ivl_done, vrms > thr_ov, int'(hold_ivl));
        d[2]  = qual(2, smp_stb, vms < thr_sag, int'(hold_smp));
        d[10] = qual(3, smp_stb, vms > thr_surge, int'(hold_smp));
        d[6]  = ivl_done && (irms > thr_oc);
        nxt = old;
        if (ivl_done) nxt &= sticky_cfg;
        nxt |= d;
        if (clr_stb) nxt &= ~clr_mask;
        if (frc_stb) nxt |= frc_mask;
        ef = |(old & mask_fault);
        ec = |(old & mask_crit);
        m_st = nxt;
        @(posedge clk);
        #1;
        chk(cur_tag, status, m_st);
        chk({cur_tag, "/R10 fault"}, {23'd0, pin_fault}, {23'd0, ef});
        chk({cur_tag, "/R10 crit"}, {23'd0, pin_crit}, {23'd0, ec});
    endtask

    task automatic ivl(input logic [23:0] v);
        vrms = v; ivl_done = 1; cyc(); ivl_done = 0; cyc();
    endtask

    task automatic smp(input logic [23:0] v);
        vms = v; smp_stb = 1; cyc(); smp_stb = 0;
    endtask

    task automatic wipe();
        clr_stb = 1; clr_mask = '1; cyc(); clr_stb = 0; clr_mask = '0; cyc();
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7051));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 status", status, 24'd0);
        chk("R1 pins", {22'd0, pin_fault, pin_crit}, 24'd0);
        rst_n = 1;
        cyc();

        // R2: exact interval hold-off of 3 on under-voltage
        cur_tag = "R2"; hold_ivl = 3;
        ivl(24'd90000); ivl(24'd90000);
        chk("R2 not yet", {23'd0, status[0]}, 24'd0);
        ivl(24'd90000);
        chk("R2 after 3", {23'd0, status[0]}, 24'd1);
        ivl(24'd120000); wipe();

        // R3: over-voltage with hold-off 0 acting as 1
        cur_tag = "R3"; hold_ivl = 0;
        ivl(24'd140000);
        chk("R3 immediate", {23'd0, status[1]}, 24'd1);
        ivl(24'd120000); wipe();

        // R4: interruption restarts the run; idle cycles do not count
        cur_tag = "R4"; hold_ivl = 3;
        ivl(24'd90000); ivl(24'd90000); ivl(24'd120000);
        ivl(24'd90000); ivl(24'd90000);
        vrms = 24'd90000; repeat (5) cyc();
        chk("R4 broken run", {23'd0, status[0]}, 24'd0);
        ivl(24'd90000);
        chk("R4 run done", {23'd0, status[0]}, 24'd1);
        ivl(24'd120000); wipe();

        // R5: sag and surge per sample, shared hold-off 4
        cur_tag = "R5"; hold_smp = 4;
        repeat (3) smp(24'd90000);
        chk("R5 sag early", {23'd0, status[2]}, 24'd0);
        smp(24'd90000);
        chk("R5 sag set", {23'd0, status[2]}, 24'd1);
        repeat (4) smp(24'd230000);
        chk("R5 surge set", {23'd0, status[10]}, 24'd1);
        smp(24'd150000); wipe();

        // R6 with R10: over-current on the fault pin through mask 0x000440
        cur_tag = "R6"; irms = 24'd60000;
        ivl(24'd120000);
        chk("R6 oc set", {23'd0, status[6]}, 24'd1);
        chk("R10 fault pin", {23'd0, pin_fault}, 24'd1);
        irms = 24'd0; wipe();

        // R7: non-sticky bits drop at the next interval, sticky kept
        cur_tag = "R7"; sticky_cfg = 24'h000001;
        frc_stb = 1; frc_mask = 24'h800003; cyc(); frc_stb = 0; frc_mask = '0;
        ivl(24'd120000);
        chk("R7 policy", status, 24'h000001);
        wipe();

        // R8/R9: clear beats detection, force beats clear
        cur_tag = "R8"; sticky_cfg = '1; irms = 24'd60000;
        clr_stb = 1; clr_mask = 24'h000040; ivl_done = 1; vrms = 24'd120000; cyc();
        ivl_done = 0; clr_stb = 0; irms = 0; cyc();
        chk("R8 clear over detect", {23'd0, status[6]}, 24'd0);
        cur_tag = "R9";
        clr_stb = 1; clr_mask = 24'h00F000; frc_stb = 1; frc_mask = 24'h003000; cyc();
        clr_stb = 0; frc_stb = 0; cyc();
        chk("R9 force wins", status, 24'h003000);
        wipe();

        // R11: random mix against the model
        cur_tag = "R11";
        for (int ph = 0; ph < 8; ph++) begin
            sticky_cfg = $urandom; mask_fault = $urandom; mask_crit = $urandom;
            hold_ivl = 8'($urandom_range(0, 5)); hold_smp = 8'($urandom_range(0, 5));
            for (int k = 0; k < 300; k++) begin
                vrms = 24'($urandom_range(85000, 140000));
                irms = 24'($urandom_range(40000, 60000));
                vms = 24'($urandom_range(85000, 235000));
                ivl_done = ($urandom_range(0, 3) == 0);
                smp_stb = ($urandom_range(0, 1) == 0);
                frc_stb = ($urandom_range(0, 15) == 0); frc_mask = $urandom;
                clr_stb = ($urandom_range(0, 7) == 0); clr_mask = $urandom;
                cyc();
            end
        end
        ivl_done = 0; smp_stb = 0; frc_stb = 0; clr_stb = 0;
        cyc();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule